// File: doc/BRIEF.md
# Read-port reset and block-entry sequencer

This sequencer runs on the read clock of a two-port field memory. It watches a read-reset strobe together with the read-enable and output-enable pins. On an accepted reset it loads the read pointer with zero. If the first four clocks of the reset carry a fixed key pattern on output-enable and read-enable, the block takes over output-enable as a serial input. It then shifts in a 13-bit block number and loads the pointer with the start address of that block. While the pin serves as an address line, the sequencer holds the data outputs disabled. After the load it enforces a read-latency window before sequential reading may resume.

The data path and the storage array consume the pointer-load strobe and value, the output-disable override and the latency-busy flag. A block number beyond the last valid block locks the sequencer with an error flag until a plain reset arrives.

Top module: `rd_reset_seq`

## Requirements
- R1: On a clock edge with `rst_rd_i` high, `rd_en_i` high and the sequencer armed, `ptr_load_o` is high for exactly the following cycle with `ptr_val_o` = 0. This edge is clock 1 of the reset.
- R2: If `rst_rd_i` is seen high while armed but `rd_en_i` is low, the reset is held pending. The zero load happens on the first later edge with `rd_en_i` high, even if `rst_rd_i` has fallen by then.
- R3: Block entry needs `out_en_i`=0 and `rd_en_i`=1 on clocks 1 and 2, and `out_en_i`=1 and `rd_en_i`=0 on clocks 3 and 4. On any mismatch the reset stays a plain zero reset: there is no further load and `oe_force_off_o` stays low.
- R4: Once the key passes on clock 4, `oe_force_off_o` is high from the cycle after clock 4, whatever level `out_en_i` has.
- R5: `out_en_i` is sampled on clocks 5 to 17 as a 13-bit block number N, most significant bit first. If N ≤ 6143, `ptr_load_o` pulses for the cycle after clock 17 with `ptr_val_o` = 12 + 40·N.
- R6: After a valid block load, `lat_busy_o` is high from the cycle after clock 17 through the cycle after clock 71, which is 55 cycles. Both `lat_busy_o` and `oe_force_off_o` are low after clock 72, so reading may restart on clock 73.
- R7: If N > 6143, `err_o` goes high after clock 17 with no pointer load, and `oe_force_off_o` stays high. Both remain high until the next accepted reset, which clears `err_o` and loads zero.
- R8: A new reset is accepted only after two conditions hold since the last accepted reset. There must be at least 56 edges with `rd_en_i` high. There must also be at least 2 edges with `rd_en_i` high and `rst_rd_i` low, with no high `rst_rd_i` after them. Otherwise a high `rst_rd_i` is ignored (no load). No reset is accepted during the key check or the address shift.
- R9: After `rst_ni` all outputs are low and the sequencer is armed, so the first reset is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_rd_i | input | 1 | Read-pointer reset strobe |
| rd_en_i | input | 1 | Read enable (pointer advance) |
| out_en_i | input | 1 | Output enable pin, serial block number during entry |
| ptr_load_o | output | 1 | One-cycle pointer-load strobe |
| ptr_val_o | output | 18 | Pointer load value |
| oe_force_off_o | output | 1 | Forces the data outputs to high impedance |
| lat_busy_o | output | 1 | Read-latency window running |
| err_o | output | 1 | Out-of-range block number, sequencer locked |

## Verification
Every output is registered one stage after the edge that causes it. The zero load shows in the cycle after clock 1, and the block load and error in the cycle after clock 17. The force-off rises after clock 4, and busy and force-off fall after clock 72. The bench drives inputs on the falling edge and samples one nanosecond after each rising edge. Each check therefore reads exactly the result of the edge just taken, and the bench keeps its own clock index within each reset sequence to compare against those positions.

// File: rtl/rd_reset_seq_pkg.sv
package rd_reset_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHK   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LOCK  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rd_reset_arm.sv
module rd_reset_arm #(
  parameter int MIN_PASS = 56,
  parameter int LOW_MIN  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_rd_i,
  input  logic rd_en_i,
  input  logic idle_i,
  output logic trig_o
);
  localparam int AW = $clog2(MIN_PASS + 1);
  localparam int LW = $clog2(LOW_MIN + 1);

  logic [AW-1:0] act_q;
  logic [LW-1:0] low_q;
  logic          pend_q;
  logic          armed, req;

  assign armed  = idle_i && (act_q == AW'(MIN_PASS)) && (low_q == LW'(LOW_MIN));
  assign req    = (rst_rd_i && armed) || pend_q;
  assign trig_o = req && rd_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= AW'(MIN_PASS);
      low_q  <= LW'(LOW_MIN);
      pend_q <= 1'b0;
    end else if (trig_o) begin
      act_q  <= '0;
      low_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= req && !rd_en_i;
      if (rd_en_i && act_q != AW'(MIN_PASS)) act_q <= act_q + AW'(1);
      if (rst_rd_i) low_q <= '0;
      else if (rd_en_i && low_q != LW'(LOW_MIN)) low_q <= low_q + LW'(1);
    end
  end
endmodule

// File: rtl/rd_reset_ctrl.sv
module rd_reset_ctrl
  import rd_reset_seq_pkg::*;
#(
  parameter int BLK_W     = 13,
  parameter int PTR_W     = 18,
  parameter int BLK_BASE  = 12,
  parameter int BLK_WORDS = 40,
  parameter int MAX_BLK   = 6143
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             rd_en_i,
  input  logic             out_en_i,
  output seq_state_e       state_o,
  output logic             ptr_load_o,
  output logic [PTR_W-1:0] ptr_val_o,
  output logic             lat_start_o
);
  localparam int STEP_LAST = 3 + BLK_W;
  localparam int SW        = $clog2(STEP_LAST + 1);

  seq_state_e       state_q;
  logic [SW-1:0]    step_q;
  logic [BLK_W-1:0] sh_q;
  logic [BLK_W-1:0] full;
  logic             key_ok, last, blk_ok;

  assign full   = {sh_q[BLK_W-2:0], out_en_i};
  assign key_ok = (step_q == SW'(1)) ? (!out_en_i && rd_en_i) : (out_en_i && !rd_en_i);
  assign last   = (state_q == ST_SHIFT) && (step_q == SW'(STEP_LAST));
  assign blk_ok = (full <= BLK_W'(MAX_BLK));

  assign state_o     = state_q;
  assign lat_start_o = last && blk_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      sh_q       <= '0;
      ptr_load_o <= 1'b0;
      ptr_val_o  <= '0;
    end else begin
      ptr_load_o <= 1'b0;
      if (trig_i) begin
        // clock 1: zero load, key bit 1 checked here
        ptr_load_o <= 1'b1;
        ptr_val_o  <= '0;
        step_q     <= SW'(1);
        state_q    <= out_en_i ? ST_IDLE : ST_CHK;
      end else begin
        unique case (state_q)
          ST_CHK: begin
            step_q <= step_q + SW'(1);
            if (!key_ok) state_q <= ST_IDLE;
            else if (step_q == SW'(3)) state_q <= ST_SHIFT;
          end
          ST_SHIFT: begin
            step_q <= step_q + SW'(1);
            sh_q   <= full;
            if (last) begin
              if (blk_ok) begin
                ptr_load_o <= 1'b1;
                ptr_val_o  <= PTR_W'(BLK_BASE) + PTR_W'(BLK_WORDS) * PTR_W'(full);
                state_q    <= ST_IDLE;
              end else begin
                state_q <= ST_LOCK;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rd_reset_lat.sv
module rd_reset_lat #(
  parameter int LAT_CLKS = 55
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(LAT_CLKS + 1);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (start_i)   cnt_q <= CW'(LAT_CLKS);
    else if (busy_o)    cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/rd_reset_seq.sv
module rd_reset_seq
  import rd_reset_seq_pkg::*;
#(
  parameter int BLK_W     = 13,
  parameter int PTR_W     = 18,
  parameter int BLK_BASE  = 12,
  parameter int BLK_WORDS = 40,
  parameter int MAX_BLK   = 6143,
  parameter int LAT_CLKS  = 55,
  parameter int MIN_PASS  = 56,
  parameter int LOW_MIN   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_rd_i,
  input  logic             rd_en_i,
  input  logic             out_en_i,
  output logic             ptr_load_o,
  output logic [PTR_W-1:0] ptr_val_o,
  output logic             oe_force_off_o,
  output logic             lat_busy_o,
  output logic             err_o
);
  seq_state_e state;
  logic       trig, lat_start, idle;

  assign idle = (state == ST_IDLE) || (state == ST_LOCK);

  rd_reset_arm #(.MIN_PASS(MIN_PASS), .LOW_MIN(LOW_MIN)) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_rd_i(rst_rd_i), .rd_en_i(rd_en_i),
    .idle_i(idle), .trig_o(trig)
  );

  rd_reset_ctrl #(
    .BLK_W(BLK_W), .PTR_W(PTR_W), .BLK_BASE(BLK_BASE),
    .BLK_WORDS(BLK_WORDS), .MAX_BLK(MAX_BLK)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .rd_en_i(rd_en_i),
    .out_en_i(out_en_i), .state_o(state), .ptr_load_o(ptr_load_o),
    .ptr_val_o(ptr_val_o), .lat_start_o(lat_start)
  );

  rd_reset_lat #(.LAT_CLKS(LAT_CLKS)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(lat_start), .busy_o(lat_busy_o)
  );

  assign err_o          = (state == ST_LOCK);
  assign oe_force_off_o = (state == ST_SHIFT) || (state == ST_LOCK) || lat_busy_o;
endmodule

// File: rtl/rd_reset_seq_chk.sv
module rd_reset_seq_chk #(
  parameter int PTR_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ptr_load_o,
  input logic [PTR_W-1:0] ptr_val_o,
  input logic             oe_force_off_o,
  input logic             lat_busy_o,
  input logic             err_o
);
  // R1
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_o |=> !ptr_load_o);
  // R5
  load_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_o |-> (ptr_val_o <= PTR_W'(12 + 40 * 6143)));
  // R6
  blk_load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_load_o && ptr_val_o != '0) |-> lat_busy_o);
  // R6
  busy_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_busy_o |-> oe_force_off_o);
  // R7
  err_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (oe_force_off_o && !lat_busy_o));
  // R7
  err_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !ptr_load_o);
endmodule

bind rd_reset_seq rd_reset_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ptr_load_o(ptr_load_o), .ptr_val_o(ptr_val_o),
  .oe_force_off_o(oe_force_off_o), .lat_busy_o(lat_busy_o), .err_o(err_o)
);

// File: tb/sim_rd_reset_seq.sv
`timescale 1ns/1ps
module sim_rd_reset_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_rd_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        out_en_i = 1'b0;
  logic        ptr_load_o;
  logic [17:0] ptr_val_o;
  logic        oe_force_off_o, lat_busy_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  rd_reset_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_rd_i(rst_rd_i), .rd_en_i(rd_en_i),
    .out_en_i(out_en_i), .ptr_load_o(ptr_load_o), .ptr_val_o(ptr_val_o),
    .oe_force_off_o(oe_force_off_o), .lat_busy_o(lat_busy_o), .err_o(err_o)
  );

  function automatic int exp_ptr(input int n);
    return 12 + 40 * n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge; outputs sampled 1 ns after it
  task automatic step(input logic r, input logic re, input logic oe);
    @(negedge clk_i);
    rst_rd_i = r; rd_en_i = re; out_en_i = oe;
    @(posedge clk_i);
    #1;
  endtask

  task automatic active(input int n, input logic r);
    int loads = 0;
    for (int i = 0; i < n; i++) begin
      step(r, 1'b1, 1'b1);
      if (ptr_load_o) loads++;
    end
    chk("R8 no load while active", loads, 0);
  endtask

  // fail_at: 0 key passes, 2..4 key broken on that clock
  task automatic blk(input int n, input int fail_at);
    step(1'b1, 1'b1, 1'b0);
    chk("R1 load strobe", ptr_load_o, 1);
    chk("R1 zero value", ptr_val_o, 0);
    if (fail_at == 2) step(1'b0, 1'b1, 1'b1); else step(1'b0, 1'b1, 1'b0);
    chk("R3 no force during key", oe_force_off_o, 0);
    for (int k = 3; k <= 4; k++) begin
      if (fail_at != 0 && fail_at <= k) step(1'b0, 1'b1, 1'b1);
      else step(1'b0, 1'b0, 1'b1);
    end
    if (fail_at != 0) begin
      for (int k = 5; k <= 20; k++) step(1'b0, 1'b0, k[0]);
      chk("R3 mismatch keeps force low", oe_force_off_o, 0);
      chk("R3 mismatch no load", ptr_load_o, 0);
      return;
    end
    chk("R4 force after key", oe_force_off_o, 1);
    for (int i = 12; i >= 0; i--) begin
      step(1'b0, 1'b0, logic'((n >> i) & 1));
      if (i == 0 && n > 6143) begin
        chk("R7 err raised", err_o, 1);
        chk("R7 no load", ptr_load_o, 0);
        chk("R7 force held", oe_force_off_o, 1);
        return;
      end
      if (i == 12) chk("R4 force ignores pin", oe_force_off_o, 1);
    end
    chk("R5 block load strobe", ptr_load_o, 1);
    chk("R5 block pointer", ptr_val_o, exp_ptr(n));
    chk("R6 busy after load", lat_busy_o, 1);
    for (int k = 18; k <= 72; k++) begin
      step(1'b0, 1'b0, 1'b0);
      if (k == 71) begin
        chk("R6 busy at clock 71", lat_busy_o, 1);
        chk("R6 force at clock 71", oe_force_off_o, 1);
      end
    end
    chk("R6 busy ends clock 72", lat_busy_o, 0);
    chk("R6 force ends clock 72", oe_force_off_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 load low", ptr_load_o, 0);
    chk("R9 force low", oe_force_off_o, 0);
    chk("R9 busy low", lat_busy_o, 0);
    chk("R9 err low", err_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // armed at once; oe high on clock 1 -> plain
    step(1'b1, 1'b1, 1'b1);
    chk("R9 first reset accepted", ptr_load_o, 1);
    chk("R1 zero after reset", ptr_val_o, 0);
    step(1'b0, 1'b1, 1'b0);
    chk("R1 single pulse", ptr_load_o, 0);

    // R8: too few active edges
    active(10, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R8 early reset ignored", ptr_load_o, 0);
    active(60, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R8 one low edge ignored", ptr_load_o, 0);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R8 two low edges accepted", ptr_load_o, 1);

    // R2 deferred reset
    active(60, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R2 no load while rd low", ptr_load_o, 0);
    step(1'b0, 1'b0, 1'b0);
    chk("R2 still pending", ptr_load_o, 0);
    step(1'b0, 1'b1, 1'b1);
    chk("R2 deferred load", ptr_load_o, 1);
    chk("R2 deferred zero", ptr_val_o, 0);

    // R3 key mismatches
    for (int f = 2; f <= 4; f++) begin
      active(60, 1'b0);
      blk(100, f);
    end

    // R5/R6 directed corners then random blocks
    active(60, 1'b0);
    blk(0, 0);
    active(60, 1'b0);
    blk(6143, 0);
    for (int i = 0; i < 4; i++) begin
      active(60, 1'b0);
      blk(int'($urandom_range(6143, 0)), 0);
    end

    // R7 lock and recovery
    active(60, 1'b0);
    blk(6144 + int'($urandom_range(2047, 0)), 0);
    active(60, 1'b0);
    chk("R7 err held", err_o, 1);
    chk("R7 force held in lock", oe_force_off_o, 1);
    step(1'b1, 1'b1, 1'b1);
    chk("R7 reset clears err", err_o, 0);
    chk("R7 reset loads zero", ptr_load_o, 1);
    chk("R7 force released", oe_force_off_o, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule